// File: doc/BRIEF.md
# Indexed configuration register port

This block gives a legacy I/O controller a two-address configuration window on a simple byte-wide I/O bus. The host first writes an index through the lower of the two addresses. That index selects one of 256 configuration bytes. The host then reads or writes the selected byte through the upper address. A read from either address returns the byte the index currently selects.

Writes through the data address pass through a per-index filter. Some indices are locked and drop every write. Two indices accept only one particular value, and any other value is discarded. All remaining indices take any byte. The block holds the reset defaults of the configuration bytes.

A single enable input, driven by a bit in the host bridge's own configuration space, gates the whole decode. While that input is low the port ignores all traffic. The port is disabled out of reset.

Top module: `cfgport_top`

## Requirements
- R1: After reset, byte 0xE0 holds 0x3C, 0xE2 holds 0x03, 0xE3 holds 0xFC, 0xE6 holds 0xDE, 0xE7 holds 0xFE and 0xE8 holds 0xBE. Every other byte and the index register hold 0x00. With no acknowledged read, io_rdata is 0xFF and io_ack is 0.
- R2: A write to address BASE_ADDR (default 0x03F0) loads io_wdata into the index. A read from BASE_ADDR or from BASE_ADDR+1 returns the byte the index selects.
- R3: A write to BASE_ADDR+1 leaves the selected byte unchanged when the index is below 0xE0, or is one of 0xE4, 0xE5, 0xE9 to 0xED, 0xF3, 0xF5, 0xF7, 0xF9 to 0xFB, or 0xFD to 0xFF.
- R4: At index 0xE7, a data write with any value other than 0xFE is discarded. At index 0xE8, a data write with any value other than 0xBE is discarded.
- R5: At every other index, including 0xE0 to 0xE3, 0xE6, 0xEE to 0xF2, 0xF4, 0xF6, 0xF8 and 0xFC, a data write stores io_wdata.
- R6: While port_en is 0, index writes and data writes change nothing. A read in that state gives io_ack 0 and io_rdata 0xFF in the following cycle.
- R7: A read strobe sampled at a clock edge produces io_ack = 1 and the byte on io_rdata for exactly the next cycle. When no read was sampled, io_rdata returns to 0xFF and io_ack to 0.
- R8: Strobes at any address other than BASE_ADDR and BASE_ADDR+1 change nothing and are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Decode enable from the bridge configuration bit |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, 0xFF when idle |
| io_ack | output | 1 | Registered read acknowledge |

## Verification
The hardest behaviour to show is that a discarded write really left a byte alone. This matters most at the two value-qualified indices, where the only accepted value equals the reset value, so an accepted write and a dropped one look the same. The stimulus handles this in two ways. It writes wrong values to those indices and reads them back, and it fills a writable neighbour with a marker first, so that a misrouted write would show up. Disabled-port writes are checked the same way: the index and a free byte are pre-set while the port is enabled, the port is disabled and hammered with writes, and it is then re-enabled and read back.

// File: rtl/cfgport_pkg.sv
// Package: shared policy types and functions for the configuration port.
// Assumes an 8-bit index and 8-bit data bytes.
package cfgport_pkg;

    typedef enum logic [1:0] {
        WP_OPEN   = 2'd0,
        WP_LOCKED = 2'd1,
        WP_MATCH  = 2'd2
    } wpol_t;

    // Write policy of one index.
    function automatic wpol_t write_policy(input logic [7:0] idx);
        wpol_t p;
        if (idx < 8'hE0) begin
            p = WP_LOCKED;
        end else begin
            case (idx)
                8'hE4, 8'hE5,
                8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
                8'hF3, 8'hF5, 8'hF7,
                8'hF9, 8'hFA, 8'hFB,
                8'hFD, 8'hFE, 8'hFF: p = WP_LOCKED;
                8'hE7, 8'hE8:        p = WP_MATCH;
                default:             p = WP_OPEN;
            endcase
        end
        return p;
    endfunction

    // The only value that a value-qualified index accepts.
    function automatic logic [7:0] match_value(input logic [7:0] idx);
        logic [7:0] v;
        case (idx)
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Reset default of one configuration byte.
    function automatic logic [7:0] reset_value(input logic [7:0] idx);
        logic [7:0] v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
// Address decode: turns bus strobes into index-write, data-write and read
// requests. It assumes strobes last one cycle and are gated by the enable.
module cfgport_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              any_rd
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    logic hit_idx;
    logic hit_dat;

    // Match the two port addresses and gate them with the enable.
    always_comb begin
        hit_idx = port_en && (io_addr == BASE_ADDR);
        hit_dat = port_en && (io_addr == DATA_ADDR);
        idx_wr  = io_wr && hit_idx;
        dat_wr  = io_wr && hit_dat;
        any_rd  = io_rd && (hit_idx || hit_dat);
    end
endmodule

// File: rtl/cfgport_filter.sv
// Write filter: decides whether a data write to the selected index commits.
// It assumes the index policy from the package is the whole rule set.
module cfgport_filter
    import cfgport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              dat_wr,
    input  logic [7:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit
);
    wpol_t pol;

    // Apply the open / locked / value-match rule.
    always_comb begin
        pol = write_policy(idx);
        case (pol)
            WP_OPEN:  commit = dat_wr;
            WP_MATCH: commit = dat_wr && (wdata == match_value(idx));
            default:  commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgport_bank.sv
// Configuration byte bank. Only the upper window from WIN_LO holds flops;
// every index below it is locked, so it reads as its constant zero.
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter int WIN_LO = 224
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WIN_N = (1 << IDX_W) - WIN_LO;
    localparam int OFF_W = $clog2(WIN_N);

    logic [DATA_W-1:0] mem [WIN_N];
    logic              in_win;
    logic [IDX_W-1:0]  rel;

    for (genvar g = 0; g < WIN_N; g++) begin : g_byte
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(WIN_LO + g);
        // Hold one configuration byte with its reset default.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= DATA_W'(reset_value(8'(MY_IDX)));
            else if (wr_en && idx == MY_IDX)
                mem[g] <= wdata;
        end
    end

    // Select the addressed byte; below the window it reads zero.
    always_comb begin
        in_win = (idx >= IDX_W'(WIN_LO));
        rel    = idx - IDX_W'(WIN_LO);
        rdata  = in_win ? mem[OFF_W'(rel)] : '0;
    end

    // The filter never passes a write to a locked index.
    p_wr_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> write_policy(8'(idx)) != WP_LOCKED);

    // A write that reaches a value-qualified index carries its one value.
    p_match_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && write_policy(8'(idx)) == WP_MATCH)
            |-> 8'(wdata) == match_value(8'(idx)));
endmodule

// File: rtl/cfgport_top.sv
// Indexed configuration port top. It holds the index register and the
// registered read path, and joins the decode, filter and bank. It assumes
// one-cycle strobes and a synchronous active-low reset.
module cfgport_top #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
    parameter int                IDX_W     = 8,
    parameter int                DATA_W    = 8,
    parameter int                WIN_LO    = 224
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_ack
);
    localparam logic [DATA_W-1:0] IDLE_DATA = '1;

    logic              idx_wr;
    logic              dat_wr;
    logic              any_rd;
    logic              commit;
    logic [IDX_W-1:0]  index_q;
    logic [DATA_W-1:0] sel_byte;

    cfgport_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .port_en (port_en),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .idx_wr  (idx_wr),
        .dat_wr  (dat_wr),
        .any_rd  (any_rd)
    );

    cfgport_filter #(.DATA_W(DATA_W)) u_filter (
        .dat_wr (dat_wr),
        .idx    (8'(index_q)),
        .wdata  (io_wdata),
        .commit (commit)
    );

    cfgport_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W), .WIN_LO(WIN_LO)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (commit),
        .idx   (index_q),
        .wdata (io_wdata),
        .rdata (sel_byte)
    );

    // Latch the index on an index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (idx_wr)
            index_q <= IDX_W'(io_wdata);
    end

    // Register read data and acknowledge for one cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= IDLE_DATA;
            io_ack   <= 1'b0;
        end else begin
            io_rdata <= any_rd ? sel_byte : IDLE_DATA;
            io_ack   <= any_rd;
        end
    end

    // A disabled port neither acknowledges nor returns data.
    p_dis_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !port_en) |=> (!io_ack && io_rdata == IDLE_DATA));

    // A disabled port keeps its index.
    p_dis_index_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> $stable(index_q));

    // No acknowledge without a read strobe in the previous cycle.
    p_ack_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_ack);

    // An enabled read at a port address is acknowledged next cycle.
    p_rd_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && port_en &&
         (io_addr == BASE_ADDR || io_addr == BASE_ADDR + ADDR_W'(1)))
            |=> io_ack);
endmodule

// File: tb/cfgport_top_test.sv
// Scoreboard bench: driver tasks push expected read results, a monitor
// pops and compares them at the falling edge of the cycle they are due.
module cfgport_top_test;
    localparam logic [15:0] A_IDX = 16'h03F0;
    localparam logic [15:0] A_DAT = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_ack;

    cfgport_top uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [31:0] stamp;
        logic [7:0]  exp_d;
        logic        exp_ack;
        logic [7:0]  req;
    } item_t;

    item_t       sbq[$];
    int          compared = 0;
    int          mismatched = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    logic [7:0]  model [256];
    logic [7:0]  m_idx;

    always @(posedge clk) cyc <= cyc + 1;

    // Write acceptance rule, taken from R3, R4, R5.
    function automatic bit accepts(input logic [7:0] i, input logic [7:0] v);
        if (i inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3,
                      8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]})
            return 1'b0;
        if (i == 8'hE7) return v == 8'hFE;
        if (i == 8'hE8) return v == 8'hBE;
        return 1'b1;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 256; k++) model[k] = 8'h00;
        model[8'hE0] = 8'h3C; model[8'hE2] = 8'h03; model[8'hE3] = 8'hFC;
        model[8'hE6] = 8'hDE; model[8'hE7] = 8'hFE; model[8'hE8] = 8'hBE;
        m_idx = 8'h00;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        if (port_en && a == A_IDX) m_idx = d;
        else if (port_en && a == A_DAT && accepts(m_idx, d)) model[m_idx] = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] req);
        item_t it;
        bit    hit;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        hit = port_en && (a == A_IDX || a == A_DAT);
        it.stamp = 32'(cyc + 1);
        it.exp_d = hit ? model[m_idx] : 8'hFF;
        it.exp_ack = hit;
        it.req = req;
        sbq.push_back(it);
        it.stamp = 32'(cyc + 2);   // idle afterwards (R7)
        it.exp_d = 8'hFF;
        it.exp_ack = 1'b0;
        it.req = 8'd7;
        sbq.push_back(it);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic sel_rd(input logic [7:0] i, input logic [7:0] req);
        bus_wr(A_IDX, i);
        bus_rd(A_DAT, req);
    endtask

    // Monitor: compare due items against the registered outputs.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].stamp <= 32'(cyc)) begin
            item_t it;
            it = sbq.pop_front();
            compared++;
            if (it.stamp != 32'(cyc) || io_rdata !== it.exp_d || io_ack !== it.exp_ack) begin
                mismatched++;
                $display("FAIL R%0d: rdata=%h ack=%b expected rdata=%h ack=%b (due %0d at %0d)",
                         it.req, io_rdata, io_ack, it.exp_d, it.exp_ack, it.stamp, cyc);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        compared++;
        if (io_rdata !== 8'hFF || io_ack !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: rdata=%h ack=%b expected rdata=ff ack=0", io_rdata, io_ack);
        end
        // R6: disabled after reset: reads unacknowledged, writes dropped
        bus_rd(A_DAT, 8'd6);
        bus_wr(A_IDX, 8'hE0);
        bus_wr(A_DAT, 8'h55);
        port_en = 1'b1;
        // R1: index still 0 and byte 0 reads zero
        bus_rd(A_DAT, 8'd1);
        // R1: reset defaults
        sel_rd(8'hE0, 8'd1); sel_rd(8'hE1, 8'd1); sel_rd(8'hE2, 8'd1);
        sel_rd(8'hE3, 8'd1); sel_rd(8'hE6, 8'd1); sel_rd(8'hE7, 8'd1);
        sel_rd(8'hE8, 8'd1); sel_rd(8'hF0, 8'd1);
        // R2: reading the index address returns the selected byte
        bus_wr(A_IDX, 8'hE6);
        bus_rd(A_IDX, 8'd2);
        // R5: open indices store any byte
        bus_wr(A_IDX, 8'hE1); bus_wr(A_DAT, 8'hA5); bus_rd(A_DAT, 8'd5);
        bus_wr(A_IDX, 8'hEE); bus_wr(A_DAT, 8'h5A); bus_rd(A_DAT, 8'd5);
        bus_wr(A_IDX, 8'hF4); bus_wr(A_DAT, 8'h81); bus_rd(A_DAT, 8'd5);
        bus_wr(A_IDX, 8'hFC); bus_wr(A_DAT, 8'h7E); bus_rd(A_DAT, 8'd5);
        bus_wr(A_IDX, 8'hE0); bus_wr(A_DAT, 8'h00); bus_rd(A_IDX, 8'd5);
        // R3: locked indices keep their value
        bus_wr(A_IDX, 8'h10); bus_wr(A_DAT, 8'hFF); bus_rd(A_DAT, 8'd3);
        bus_wr(A_IDX, 8'hDF); bus_wr(A_DAT, 8'h12); bus_rd(A_DAT, 8'd3);
        bus_wr(A_IDX, 8'hE4); bus_wr(A_DAT, 8'h34); bus_rd(A_DAT, 8'd3);
        bus_wr(A_IDX, 8'hEA); bus_wr(A_DAT, 8'h56); bus_rd(A_DAT, 8'd3);
        bus_wr(A_IDX, 8'hF3); bus_wr(A_DAT, 8'h78); bus_rd(A_DAT, 8'd3);
        bus_wr(A_IDX, 8'hFA); bus_wr(A_DAT, 8'h9A); bus_rd(A_DAT, 8'd3);
        bus_wr(A_IDX, 8'hFF); bus_wr(A_DAT, 8'hBC); bus_rd(A_DAT, 8'd3);
        // R4: value-qualified indices drop other values
        bus_wr(A_IDX, 8'hE6); bus_wr(A_DAT, 8'h11);
        bus_wr(A_IDX, 8'hE7); bus_wr(A_DAT, 8'h00); bus_rd(A_DAT, 8'd4);
        bus_wr(A_DAT, 8'hFF); bus_rd(A_DAT, 8'd4);
        bus_wr(A_DAT, 8'hFE); bus_rd(A_DAT, 8'd4);
        bus_wr(A_IDX, 8'hE8); bus_wr(A_DAT, 8'hBF); bus_rd(A_DAT, 8'd4);
        bus_wr(A_DAT, 8'hBE); bus_rd(A_DAT, 8'd4);
        sel_rd(8'hE6, 8'd4);
        // R8: other addresses ignored
        bus_wr(A_IDX, 8'hF0); bus_wr(A_DAT, 8'h42);
        bus_wr(16'h03F2, 8'hE1); bus_wr(16'h02F0, 8'h99); bus_wr(16'h13F1, 8'h99);
        bus_rd(16'h03F2, 8'd8); bus_rd(16'h03EF, 8'd8);
        bus_rd(A_DAT, 8'd8);
        // R6: disabled writes leave index and bytes alone
        port_en = 1'b0;
        bus_wr(A_DAT, 8'h00); bus_wr(A_IDX, 8'hE1); bus_wr(A_DAT, 8'h00);
        bus_rd(A_IDX, 8'd6);
        port_en = 1'b1;
        bus_rd(A_DAT, 8'd6);
        sel_rd(8'hE1, 8'd6);
        // R7: back-to-back reads each acknowledged once
        bus_wr(A_IDX, 8'hE3);
        bus_rd(A_DAT, 8'd7); bus_rd(A_IDX, 8'd7);
        repeat (4) @(negedge clk);
        done = 1'b1;
        if (sbq.size() != 0) begin
            mismatched++;
            $display("FAIL R7: %0d results missing, expected 0", sbq.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule